// File: doc/BRIEF.md
# Tagged Result Store with Shift-Down Read

This block is a small in-order store that sits between a sampling converter and a parallel read port. Each converted result comes in as a 12-bit sample plus a 3-bit channel tag. The result is placed in the lowest slot that holds nothing. Slot 0 is always the one shown to the reader. The output is one 16-bit word that carries its own valid flag and channel tag. A reader can therefore tell an empty store from real data without any separate status pin.

A read ends when the read strobe falls. At that point the entry in slot 0 is thrown away and every entry above it moves down one slot. While the strobe is high, the word does not change. A write and a completed read can happen in the same cycle; they are merged so that the new result still lands in the correct lowest free slot. A write to a full store is dropped, and a sticky overflow flag is set that only reset clears.

Top module: `tagged_result_fifo`

## Requirements
- R1: Reset empties every slot and clears the overflow flag; afterwards `rdWord` reads 16'h0000 and `overflow` reads 0.
- R2: `rdWord` shows slot 0 as {valid in bit 15, channel tag in bits 14..12, sample in bits 11..0}. The channel tags are A0=000, A1=001, B0=010, B1=011, C0=100, C1=101.
- R3: A write stores {tag, data} in the lowest empty slot, so results read out in arrival order; the first write into an empty store appears on `rdWord` on the clock edge that samples `wrEn`.
- R4: A read completes on the clock edge that first samples `rdStrobe` low after it was high. That edge discards slot 0 and moves every higher entry down one slot. While `rdStrobe` stays high, `rdWord` holds its value.
- R5: When a write and a read completion fall on the same edge, the shift and the insert are merged. The new entry goes to the lowest free slot after the shift, with no loss and no reordering, and a full store accepts the write without overflow.
- R6: A write to a full store (six entries) with no read completing on that edge is dropped, and `overflow` rises on that edge. `overflow` stays high until reset.
- R7: A read completion on an empty store changes nothing: `rdWord` stays 16'h0000 and a later write still lands in slot 0.
- R8: An empty store drives bit 15 low and all other output bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Store a new result this cycle |
| wrTag | input | 3 | Channel tag of the new result |
| wrData | input | 12 | Sample value of the new result |
| rdStrobe | input | 1 | Read strobe; its falling edge completes a read |
| rdWord | output | 16 | {valid, tag, sample} of slot 0 |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
A write is visible on `rdWord` right after the rising edge that samples `wrEn`. A read completion takes effect on the first rising edge that sees `rdStrobe` low after it was high. Any change in `overflow` also shows after that same edge. The bench therefore drives inputs on the falling edge and samples a quarter period after the next rising edge, so each expected value refers to exactly one edge. A step that holds the strobe high is checked against the unchanged word, which tests the hold rule directly.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  parameter int DATA_W = 12;
  parameter int TAG_W  = 3;
  localparam int WORD_W = 1 + TAG_W + DATA_W;

  typedef struct packed {
    logic              valid;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
  } entry_t;

  typedef struct packed {
    logic doWrite;
    logic doShift;
  } strobe_t;
endpackage

// File: rtl/fifo_control.sv
module fifo_control
  import fifo_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    rdStrobe,
  input  logic    full,
  input  logic    empty,
  output strobe_t strb,
  output logic    overflow
);
  logic prevRd;
  logic readDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevRd <= 1'b0;
    else       prevRd <= rdStrobe;
  end

  assign readDone     = prevRd & ~rdStrobe;
  assign strb.doShift = readDone & ~empty;
  assign strb.doWrite = wrEn & (~full | strb.doShift);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  overflow <= 1'b0;
    else if (wrEn && full && !strb.doShift)     overflow <= 1'b1;
  end

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R6
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !readDone) |=> overflow);

  // R4
  shift_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doShift |-> ($past(rdStrobe) && !rdStrobe));
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  output entry_t            head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  entry_t [DEPTH-1:0] slots;
  entry_t [DEPTH-1:0] shifted;
  entry_t [DEPTH-1:0] nextSlots;
  logic   [CNT_W-1:0] insertAt;

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) count = count + CNT_W'(slots[i].valid);
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gShift
      if (g == DEPTH - 1) begin : gTop
        assign shifted[g] = strb.doShift ? '0 : slots[g];
      end else begin : gMid
        assign shifted[g] = strb.doShift ? slots[g+1] : slots[g];
      end
    end
  endgenerate

  assign insertAt = count - CNT_W'(strb.doShift);

  always_comb begin
    nextSlots = shifted;
    for (int i = 0; i < DEPTH; i++) begin
      if (strb.doWrite && insertAt == CNT_W'(i)) begin
        nextSlots[i].valid = 1'b1;
        nextSlots[i].tag   = wrTag;
        nextSlots[i].data  = wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slots <= '0;
    else       slots <= nextSlots;
  end

  assign head = slots[0];

  // R3
  lone_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doWrite && !strb.doShift) |=> (count == $past(count) + CNT_W'(1)));

  // R4
  lone_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doShift && !strb.doWrite) |=> (count == $past(count) - CNT_W'(1)));

  // R5
  merged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doShift && strb.doWrite) |=> (count == $past(count)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.doShift && !strb.doWrite) |=> $stable(slots));

  // R8
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (head == '0));

  // R3
  generate
    for (g = 0; g < DEPTH - 1; g++) begin : gContig
      contig_chk: assert property (@(posedge clk) disable iff (!rstN)
        slots[g+1].valid |-> slots[g].valid);
    end
  endgenerate
endmodule

// File: rtl/tagged_result_fifo.sv
module tagged_result_fifo
  import fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  output logic [WORD_W-1:0] rdWord,
  output logic              overflow
);
  strobe_t            strb;
  entry_t             head;
  logic [CNT_W-1:0]   count;
  logic               full;
  logic               empty;

  fifo_control uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdStrobe(rdStrobe),
    .full(full), .empty(empty), .strb(strb), .overflow(overflow)
  );

  fifo_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrTag(wrTag), .wrData(wrData),
    .head(head), .count(count), .full(full), .empty(empty)
  );

  assign rdWord = {head.valid, head.tag, head.data};

  // R2
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdWord[WORD_W-1] == (count != '0));
endmodule

// File: tb/tb_tagged_result_fifo.sv
module tb_tagged_result_fifo;
  localparam int PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic        wr;
    logic [2:0]  tag;
    logic [11:0] data;
    logic        rd;
    logic [15:0] expWord;
    logic        expOv;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 3'd0, 12'h000, 1'b0, 16'h0000, 1'b0, 4'd8}, // R8 idle empty
    '{1'b1, 3'd0, 12'h111, 1'b0, 16'h8111, 1'b0, 4'd3}, // R3 A0 first write
    '{1'b1, 3'd1, 12'h222, 1'b0, 16'h8111, 1'b0, 4'd3}, // R3 A1 stacks above
    '{1'b0, 3'd0, 12'h000, 1'b1, 16'h8111, 1'b0, 4'd4}, // R4 strobe high holds
    '{1'b0, 3'd0, 12'h000, 1'b0, 16'h9222, 1'b0, 4'd4}, // R4 fall shifts
    '{1'b1, 3'd2, 12'h333, 1'b0, 16'h9222, 1'b0, 4'd3}, // R3 B0
    '{1'b1, 3'd3, 12'h444, 1'b0, 16'h9222, 1'b0, 4'd3}, // R3 B1
    '{1'b0, 3'd0, 12'h000, 1'b1, 16'h9222, 1'b0, 4'd4}, // R4
    '{1'b1, 3'd4, 12'h555, 1'b0, 16'hA333, 1'b0, 4'd5}, // R5 merged
    '{1'b0, 3'd0, 12'h000, 1'b1, 16'hA333, 1'b0, 4'd4}, // R4
    '{1'b0, 3'd0, 12'h000, 1'b0, 16'hB444, 1'b0, 4'd2}, // R2 B1 tag
    '{1'b0, 3'd0, 12'h000, 1'b1, 16'hB444, 1'b0, 4'd4}, // R4
    '{1'b0, 3'd0, 12'h000, 1'b0, 16'hC555, 1'b0, 4'd5}, // R5 C0 kept order
    '{1'b0, 3'd0, 12'h000, 1'b1, 16'hC555, 1'b0, 4'd4}, // R4
    '{1'b0, 3'd0, 12'h000, 1'b0, 16'h0000, 1'b0, 4'd8}, // R8 drained
    '{1'b0, 3'd0, 12'h000, 1'b1, 16'h0000, 1'b0, 4'd7}, // R7
    '{1'b0, 3'd0, 12'h000, 1'b0, 16'h0000, 1'b0, 4'd7}, // R7 empty read
    '{1'b1, 3'd5, 12'h666, 1'b0, 16'hD666, 1'b0, 4'd7}  // R7 write lands slot 0
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrTag = '0;
  logic [11:0] wrData = '0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdWord;
  logic        overflow;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  tagged_result_fifo dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrTag(wrTag), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdWord(rdWord), .overflow(overflow)
  );

  task automatic step(input logic w, input logic [2:0] t, input logic [11:0] d, input logic r);
    @(negedge clk);
    wrEn = w; wrTag = t; wrData = d; rdStrobe = r;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic check(input string req, input logic [15:0] expW, input logic expO);
    total++;
    if (rdWord !== expW || overflow !== expO) begin
      bad++;
      $display("FAIL %s: word=%h ovf=%b expected word=%h ovf=%b", req, rdWord, overflow, expW, expO);
    end
  endtask

  task automatic readOut(input string req, input logic [15:0] expW, input logic expO);
    step(1'b0, 3'd0, 12'h000, 1'b1);
    step(1'b0, 3'd0, 12'h000, 1'b0);
    check(req, expW, expO);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; rdStrobe = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD/4);
    check("R1", 16'h0000, 1'b0);   // R1 held in reset
    doReset();
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].tag, VEC[i].data, VEC[i].rd);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].expWord, VEC[i].expOv);
    end

    // R6 fill to six, then overflow
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 3'(i), 12'(12'h7A0 + i), 1'b0);
    end
    check("R6 full no ovf", 16'hD666, 1'b0);
    step(1'b1, 3'd1, 12'hBAD, 1'b0);
    check("R6 ovf raised", 16'hD666, 1'b1);
    step(1'b0, 3'd0, 12'h000, 1'b0);
    check("R6 ovf sticky", 16'hD666, 1'b1);
    readOut("R6 order", 16'h87A0, 1'b1);
    readOut("R2 A1 tag", 16'h97A1, 1'b1);
    readOut("R2 B0 tag", 16'hA7A2, 1'b1);
    readOut("R2 B1 tag", 16'hB7A3, 1'b1);
    readOut("R2 C0 tag", 16'hC7A4, 1'b1);
    readOut("R6 dropped write absent", 16'h0000, 1'b1);

    // R1 reset clears content and flag
    step(1'b1, 3'd2, 12'h123, 1'b0);
    doReset();
    #(PERIOD/4);
    check("R1 reset clears", 16'h0000, 1'b0);

    // R5 full store, write merged with read completion
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 3'd1, 12'(12'h100 + i), 1'b0);
    end
    step(1'b0, 3'd0, 12'h000, 1'b1);
    step(1'b1, 3'd5, 12'hFED, 1'b0);
    check("R5 merged at full", 16'h9101, 1'b0);
    for (int i = 2; i < 6; i++) begin
      readOut("R5 order", 16'(16'h9100 + i), 1'b0);
    end
    readOut("R5 new entry last", 16'hDFED, 1'b0);
    readOut("R8 empty again", 16'h0000, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule